// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a 24-line general-purpose parallel I/O peripheral that sits on a CPU's byte-wide data bus. It exposes three data locations and one command location. Software programs pin directions by writing a command byte with its top bit set. A command byte with its top bit clear flips one line of the third port high or low and leaves the other lines of that port as they were.

The lines are grouped into port A (8 lines), port B (8 lines), and port C, which is split into a 4-line upper group and a 4-line lower group. Each of the four groups is independently an input or an output, which gives sixteen direction combinations. Output groups drive a latched value. Reads of input groups return the live pins with no latch in between. The bus data lines are modelled as a separate input bus and output bus with an output-enable.

Two interrupt-enable flags are updated whenever the single-bit command addresses their assigned port C line. Each flag gates one external request line onto an interrupt output.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset, every port group is an input: `pa_oe`, `pb_oe` and `pc_oe` are all zero. Both interrupt outputs are zero, and `dout_oe` is zero while no read is in progress.
- R2: A write to address 3 with data bit 7 set is a direction word. Data bit 4 makes port A an input, bit 3 the port C upper nibble, bit 1 port B, and bit 0 the port C lower nibble, where 1 means input. From the next cycle, each output-enable is the inverse of its direction bit; both `pc_oe` bits of a nibble follow that nibble.
- R3: A direction word clears the port A and port C output latches to zero and clears both interrupt-enable flags.
- R4: A write to address 3 with data bit 7 clear sets the port C latch bit indexed by data bits 3..1 (0 to 7) to the value of data bit 0. All other port C bits keep their value, and data bits 6..4 have no effect.
- R5: Writes to address 0, 1 and 2 load the port A, B and C output latches. An output group drives its latch on `pa_out`/`pb_out`/`pc_out`, and a read of an output group returns the latch.
- R6: A read of an input group returns the live pin value in the same cycle. A port C read combines the nibbles: latched bits for output nibbles, pin bits for input nibbles.
- R7: A read of address 3 returns 0x00.
- R8: Interrupt output k equals request k AND enable flag k. Flag 0 follows every single-bit command on port C bit 4, and flag 1 follows every single-bit command on port C bit 2.
- R9: With `cs_n` high, writes have no effect and `dout_oe` stays low. `dout_oe` is high exactly while `cs_n` and `rd_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, sampled each rising edge |
| addr | input | 2 | 0 = A, 1 = B, 2 = C, 3 = command |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| dout_oe | output | 1 | Bus drive enable during reads |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C per-line drive enable |
| irq_req | input | 2 | Raw interrupt request conditions |
| irq | output | 2 | Gated interrupt outputs |

## Verification
The bench builds the block with its default parameters: two request lines, with their enable flags mapped to port C bits 4 and 2. With this mapping, one single-bit command moves a visible port C line and an interrupt output together, so both effects can be checked at the ports. Mixed-nibble port C reads in both orientations cover the per-nibble read path. Single-bit commands carrying nonzero ignored bits confirm that those bits are dropped.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int NIRQ   = 2;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CMD = 2'd3
    } sel_e;

    // 1 = group is an input
    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } dir_t;

    typedef struct packed {
        dir_t              dir;
        logic [BYTE_W-1:0] pa;
        logic [BYTE_W-1:0] pb;
        logic [BYTE_W-1:0] pc;
        logic [NIRQ-1:0]   inte;
    } ppio_state_t;
endpackage

// File: rtl/ppio_cmd_decode.sv
module ppio_cmd_decode
    import ppio_pkg::*;
(
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] din,
    output logic              wr_a,
    output logic              wr_b,
    output logic              wr_c,
    output logic              mode_we,
    output logic              bsr_we,
    output logic [IDX_W-1:0]  bsr_idx,
    output logic              bsr_val
);
    logic cmd_hit;

    always_comb begin
        cmd_hit = we && (sel_e'(addr) == SEL_CMD);
        wr_a    = we && (sel_e'(addr) == SEL_A);
        wr_b    = we && (sel_e'(addr) == SEL_B);
        wr_c    = we && (sel_e'(addr) == SEL_C);
        mode_we = cmd_hit && din[BYTE_W-1];
        bsr_we  = cmd_hit && !din[BYTE_W-1];
        bsr_idx = din[IDX_W:1];
        bsr_val = din[0];
    end
endmodule

// File: rtl/ppio_regs.sv
module ppio_regs
    import ppio_pkg::*;
#(
    parameter logic [NIRQ*IDX_W-1:0] INTE_SEL = {3'd2, 3'd4}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              wr_c,
    input  logic              mode_we,
    input  logic              bsr_we,
    input  logic [IDX_W-1:0]  bsr_idx,
    input  logic              bsr_val,
    input  logic [BYTE_W-1:0] din,
    output ppio_state_t       st
);
    ppio_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_we) begin
            st_d.dir.a_in  = din[4];
            st_d.dir.cu_in = din[3];
            st_d.dir.b_in  = din[1];
            st_d.dir.cl_in = din[0];
            st_d.pa        = '0;
            st_d.pc        = '0;
            st_d.inte      = '0;
        end else if (bsr_we) begin
            st_d.pc[bsr_idx] = bsr_val;
            for (int k = 0; k < NIRQ; k++) begin
                if (bsr_idx == INTE_SEL[k*IDX_W +: IDX_W]) begin
                    st_d.inte[k] = bsr_val;
                end
            end
        end else begin
            if (wr_a) st_d.pa = din;
            if (wr_b) st_d.pb = din;
            if (wr_c) st_d.pc = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dir  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/ppio_rdmux.sv
module ppio_rdmux
    import ppio_pkg::*;
(
    input  logic [1:0]        addr,
    input  ppio_state_t       st,
    input  logic [BYTE_W-1:0] pa_in,
    input  logic [BYTE_W-1:0] pb_in,
    input  logic [BYTE_W-1:0] pc_in,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] a_val, b_val, c_val;

    always_comb begin
        a_val = st.dir.a_in ? pa_in : st.pa;
        b_val = st.dir.b_in ? pb_in : st.pb;
        c_val[BYTE_W-1:NIB_W] = st.dir.cu_in ? pc_in[BYTE_W-1:NIB_W] : st.pc[BYTE_W-1:NIB_W];
        c_val[NIB_W-1:0]      = st.dir.cl_in ? pc_in[NIB_W-1:0]      : st.pc[NIB_W-1:0];
        unique case (sel_e'(addr))
            SEL_A:   rdata = a_val;
            SEL_B:   rdata = b_val;
            SEL_C:   rdata = c_val;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter logic [NIRQ*IDX_W-1:0] INTE_SEL = {3'd2, 3'd4}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_oe,
    input  logic [BYTE_W-1:0] pa_in,
    output logic [BYTE_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [BYTE_W-1:0] pb_in,
    output logic [BYTE_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [BYTE_W-1:0] pc_in,
    output logic [BYTE_W-1:0] pc_out,
    output logic [BYTE_W-1:0] pc_oe,
    input  logic [NIRQ-1:0]   irq_req,
    output logic [NIRQ-1:0]   irq
);
    logic             we;
    logic             wr_a, wr_b, wr_c, mode_we, bsr_we, bsr_val;
    logic [IDX_W-1:0] bsr_idx;
    ppio_state_t      st;
    logic [BYTE_W-1:0] rdata;

    assign we = !cs_n && !wr_n;

    ppio_cmd_decode u_dec (
        .we      (we),
        .addr    (addr),
        .din     (din),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wr_c    (wr_c),
        .mode_we (mode_we),
        .bsr_we  (bsr_we),
        .bsr_idx (bsr_idx),
        .bsr_val (bsr_val)
    );

    ppio_regs #(.INTE_SEL(INTE_SEL)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wr_c    (wr_c),
        .mode_we (mode_we),
        .bsr_we  (bsr_we),
        .bsr_idx (bsr_idx),
        .bsr_val (bsr_val),
        .din     (din),
        .st      (st)
    );

    ppio_rdmux u_rd (
        .addr  (addr),
        .st    (st),
        .pa_in (pa_in),
        .pb_in (pb_in),
        .pc_in (pc_in),
        .rdata (rdata)
    );

    assign dout    = rdata;
    assign dout_oe = !cs_n && !rd_n;
    assign pa_out  = st.pa;
    assign pb_out  = st.pb;
    assign pc_out  = st.pc;
    assign pa_oe   = !st.dir.a_in;
    assign pb_oe   = !st.dir.b_in;
    assign pc_oe   = {{NIB_W{!st.dir.cu_in}}, {NIB_W{!st.dir.cl_in}}};

    for (genvar k = 0; k < NIRQ; k++) begin : g_irq
        assign irq[k] = irq_req[k] && st.inte[k];
    end
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk
    import ppio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [1:0]        addr,
    input logic [BYTE_W-1:0] din,
    input logic [BYTE_W-1:0] dout,
    input logic              dout_oe,
    input logic [BYTE_W-1:0] pa_out,
    input logic              pa_oe,
    input logic              pb_oe,
    input logic [BYTE_W-1:0] pc_out,
    input logic [BYTE_W-1:0] pc_oe,
    input logic [NIRQ-1:0]   irq_req,
    input logic [NIRQ-1:0]   irq
);
    logic cmd_wr, mode_wr, bsr_wr;
    assign cmd_wr  = !cs_n && !wr_n && (addr == 2'd3);
    assign mode_wr = cmd_wr && din[7];
    assign bsr_wr  = cmd_wr && !din[7];

    a_r2_dir_word: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (pa_oe == !$past(din[4])) && (pb_oe == !$past(din[1]))
                 && (pc_oe[7] == !$past(din[3])) && (pc_oe[0] == !$past(din[0])));

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (pa_out == '0) && (pc_out == '0) && (irq == '0));

    a_r4_bit_value: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr |=> pc_out[$past(din[3:1])] == $past(din[0]));

    a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr |=> ((pc_out ^ $past(pc_out)) & ~(8'd1 << $past(din[3:1]))) == 8'd0);

    a_r7_cmd_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && addr == 2'd3) |-> dout == '0);

    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~irq_req) == '0);

    a_r9_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_oe);

    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(pa_out) && $stable(pc_out) && $stable(pa_oe));
endmodule

bind ppio_ctrl ppio_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_oe (dout_oe),
    .pa_out  (pa_out),
    .pa_oe   (pa_oe),
    .pb_oe   (pb_oe),
    .pc_out  (pc_out),
    .pc_oe   (pc_oe),
    .irq_req (irq_req),
    .irq     (irq)
);

// File: tb/test_ppio_ctrl.sv
module test_ppio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout, pa_out, pb_out, pc_out, pc_oe;
    logic       dout_oe, pa_oe, pb_oe;
    logic [7:0] pa_in = 8'h5A, pb_in = 8'hC3, pc_in = 8'h96;
    logic [1:0] irq_req = '0, irq;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ppio_ctrl i_ppio_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .irq_req(irq_req), .irq(irq)
    );

    // op: 0 write, 1 read compare, 2 compare pa_out, 3 compare pc_out
    // entry = {op[1:0], addr[1:0], data[7:0], exp[7:0], req[3:0]}
    localparam int NV = 29;
    localparam logic [23:0] VEC [NV] = '{
        {2'd1, 2'd0, 8'h00, 8'h5A, 4'd1},  // R1 A input at reset
        {2'd1, 2'd2, 8'h00, 8'h96, 4'd1},  // R1 C input at reset
        {2'd0, 2'd3, 8'h80, 8'h00, 4'd2},  // all outputs
        {2'd0, 2'd0, 8'h3C, 8'h00, 4'd5},
        {2'd2, 2'd0, 8'h00, 8'h3C, 4'd5},  // R5 latch on pins
        {2'd1, 2'd0, 8'h00, 8'h3C, 4'd5},  // R5 read back latch
        {2'd0, 2'd3, 8'h7B, 8'h00, 4'd4},  // set bit5, junk in 6..4
        {2'd3, 2'd0, 8'h00, 8'h20, 4'd4},  // R4
        {2'd0, 2'd3, 8'h0E, 8'h00, 4'd4},  // clear bit7 (already 0)
        {2'd0, 2'd3, 8'h01, 8'h00, 4'd4},  // set bit0
        {2'd3, 2'd0, 8'h00, 8'h21, 4'd4},  // R4
        {2'd0, 2'd3, 8'h0A, 8'h00, 4'd4},  // clear bit5
        {2'd3, 2'd0, 8'h00, 8'h01, 4'd4},  // R4
        {2'd1, 2'd3, 8'h00, 8'h00, 4'd7},  // R7 command read
        {2'd0, 2'd3, 8'h89, 8'h00, 4'd3},  // C in, A/B out
        {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},  // R3 A cleared
        {2'd3, 2'd0, 8'h00, 8'h00, 4'd3},  // R3 C cleared
        {2'd1, 2'd2, 8'h00, 8'h96, 4'd6},  // R6 C live pins
        {2'd0, 2'd3, 8'h88, 8'h00, 4'd2},  // C upper in, lower out
        {2'd0, 2'd2, 8'h0F, 8'h00, 4'd5},
        {2'd1, 2'd2, 8'h00, 8'h9F, 4'd6},  // R6 mixed
        {2'd0, 2'd3, 8'h81, 8'h00, 4'd2},  // C upper out, lower in
        {2'd0, 2'd2, 8'hA5, 8'h00, 4'd5},
        {2'd1, 2'd2, 8'h00, 8'hA6, 4'd6},  // R6 mixed
        {2'd0, 2'd1, 8'h44, 8'h00, 4'd5},
        {2'd1, 2'd1, 8'h00, 8'h44, 4'd5},  // R5 B output latch
        {2'd0, 2'd3, 8'h92, 8'h00, 4'd2},  // A and B inputs
        {2'd1, 2'd0, 8'h00, 8'h5A, 4'd6},  // R6 A live
        {2'd1, 2'd1, 8'h00, 8'hC3, 4'd6}   // R6 B live
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
        @(negedge clk);
        cs_n = sel_n; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = dout;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", {pa_oe, pb_oe, pc_oe[7], pc_oe[0], dout_oe, irq, 1'b0}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            case (v[23:22])
                2'd0: wr(v[21:20], v[19:12]);
                2'd1: begin
                    rd(v[21:20], r);
                    check($sformatf("R%0d read", v[3:0]), r, v[11:4]);
                end
                2'd2: begin @(negedge clk); check($sformatf("R%0d pa_out", v[3:0]), pa_out, v[11:4]); end
                default: begin @(negedge clk); check($sformatf("R%0d pc_out", v[3:0]), pc_out, v[11:4]); end
            endcase
        end

        // R2 output-enables per direction word
        wr(2'd3, 8'h89);
        check("R2 oe 89", {4'h0, pa_oe, pb_oe, pc_oe[7], pc_oe[0]}, 8'h0C);
        check("R2 pc_oe 89", pc_oe, 8'h00);
        wr(2'd3, 8'h88);
        check("R2 pc_oe 88", pc_oe, 8'h0F);
        wr(2'd3, 8'h92);
        check("R2 oe 92", {4'h0, pa_oe, pb_oe, pc_oe[7], pc_oe[0]}, 8'h03);

        // R8 interrupt gating
        wr(2'd3, 8'h80);
        irq_req = 2'b11;
        @(negedge clk);
        check("R8 flags off", {6'd0, irq}, 8'h00);
        wr(2'd3, 8'h09);
        check("R8 flag0 set", {6'd0, irq}, 8'h01);
        wr(2'd3, 8'h05);
        check("R8 flag1 set", {6'd0, irq}, 8'h03);
        check("R8 pc lines", pc_out, 8'h14);
        wr(2'd3, 8'h08);
        check("R8 flag0 clr", {6'd0, irq}, 8'h02);
        irq_req = 2'b00;
        #1 check("R8 req low", {6'd0, irq}, 8'h00);
        irq_req = 2'b11;
        wr(2'd3, 8'h09);
        wr(2'd3, 8'h80);
        check("R3 flags cleared", {6'd0, irq}, 8'h00);

        // R9 deselected access
        wr(2'd0, 8'h66);
        wr(2'd0, 8'h77, 1'b1);
        check("R9 write ignored", pa_out, 8'h66);
        wr(2'd3, 8'h9B, 1'b1);
        check("R9 dir kept", {7'd0, pa_oe}, 8'h01);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0;
        #1 check("R9 no drive", {7'd0, dout_oe}, 8'h00);
        cs_n = 1'b0;
        #1 check("R9 drive", {7'd0, dout_oe}, 8'h01);
        cs_n = 1'b1; rd_n = 1'b1;

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1 reset oe", {5'd0, pa_oe, pb_oe, |pc_oe}, 8'h00);
        check("R1 reset pa", pa_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end
endmodule